// File: doc/BRIEF.md
# Programmable CPU clock generator

This block derives a processor clock from a fast system clock using an 8-bit compare value. An internal counter climbs from zero to the active compare value and then clears. Each time it clears, the processor clock output flips, so every half-period lasts compare + 1 system clocks and the output frequency is the system clock divided by 2 × (compare + 1). A compare value of 0 gives the fastest rate, half the system clock (8 MHz from 16 MHz). A value of 1 gives a quarter (4 MHz). A value of 255 gives the slowest rate, 1/512 of the system clock (31.25 kHz from 16 MHz).

Firmware may change the divisor while the clock is running by presenting a value together with a one-cycle load strobe. The value is held aside and takes effect only when the counter next clears, so no half-period is ever cut short. A stop request parks the processor clock low until the request is withdrawn. The stop is honoured at a falling transition or while the output is already low, and the clock restarts from the low phase with the counter cleared. A wait-enable flag tells the bus logic when the divide-by-two rate is in force, so that it can insert wait states at that rate only. All pins are plain control and status levels. The block has no streaming data interface, so it has no valid/ready back-pressure.

Top module: `cpu_clk_gen`

## Requirements
- R1: While reset is asserted and afterwards until the first clock edge, `cpu_clk` is low, the counter is cleared and the active compare value is 0, so `wait_en` is high.
- R2: While running with no stop request, every `cpu_clk` half-period lasts exactly (active compare + 1) system clocks, so the full period is 2 × (compare + 1).
- R3: A compare value of 0 makes `cpu_clk` flip on every system clock edge. A compare value of 255 gives half-periods of 256 system clocks.
- R4: A value presented with `div_load` high is captured at that edge and becomes active at the first counter clear after it. The half-period in progress keeps the old length. With an old compare of 0, the capture edge is itself a clear edge, so one more old-length half-period follows before the new value applies.
- R5: When several loads arrive before the counter clears, the value of the last load is the one that becomes active.
- R6: If `stop_req` is seen while `cpu_clk` is high, the high half-period completes at its full length and the output then falls. If `stop_req` is seen while `cpu_clk` is low, the output makes no further edge. For as long as `stop_req` stays high after that, `cpu_clk` stays low with no edges.
- R7: After `stop_req` falls, the clock resumes from the low phase with a cleared counter. The first low phase lasts at least (compare + 1) system clocks, and later half-periods follow R2.
- R8: `wait_en` is high exactly while the active compare value is 0 (divide-by-two), and low for every slower setting. It changes only when a new compare value becomes active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_in | input | 8 | Requested compare value (half-period = value + 1 clocks) |
| div_load | input | 1 | One-cycle strobe that captures `div_in` |
| stop_req | input | 1 | Level request to park `cpu_clk` low |
| cpu_clk | output | 1 | Divided processor clock |
| wait_en | output | 1 | High while the divide-by-two setting is active |

## Verification
The assertions take for granted that `stop_req` and `div_load` are synchronous to `clk` and settle well away from its rising edge. They also assume that no bound is placed on how soon a stop may be withdrawn or a load repeated. The stimulus keeps to this by changing every input on the falling edge of `clk` only. Loads are issued just after an output edge, so the wrap that applies them can be predicted. Stops are raised deliberately during both the high and the low phase, so both park paths are covered.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;
  // Run/park state of the output phase controller
  typedef enum logic {
    PH_RUN  = 1'b0,
    PH_PARK = 1'b1
  } park_state_t;
endpackage

// File: rtl/cpuclk_divreg.sv
// Holds the active compare value plus one pending value. A pending
// value is promoted only on a counter wrap.
module cpuclk_divreg #(
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMP_W-1:0] div_in,
  input  logic             div_load,
  input  logic             apply,
  output logic [CMP_W-1:0] act_cmp
);
  logic [CMP_W-1:0] pend_q;
  logic             pend_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_cmp <= '0;
      pend_q  <= '0;
      pend_v  <= 1'b0;
    end else begin
      if (apply && pend_v) begin
        act_cmp <= pend_q;
      end
      if (div_load) begin
        pend_q <= div_in;
        pend_v <= 1'b1;
      end else if (apply) begin
        pend_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cpuclk_counter.sv
// Half-period counter: counts up from zero and clears on wrap or while parked.
module cpuclk_counter #(
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wrap,
  input  logic [CMP_W-1:0] act_cmp,
  output logic [CMP_W-1:0] cnt,
  output logic             match
);
  assign match = (cnt == act_cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cpuclk_phase.sv
// Output phase and park control. Parking happens only when the output
// is already low or is about to fall at a match.
module cpuclk_phase
  import cpuclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic match,
  output logic cpu_clk,
  output logic running,
  output logic wrap
);
  park_state_t st;
  logic        clk_q;
  logic        park_now;

  assign running  = (st == PH_RUN);
  assign park_now = running && stop_req && (!clk_q || match);
  assign wrap     = running && (match || park_now);
  assign cpu_clk  = clk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= PH_RUN;
      clk_q <= 1'b0;
    end else begin
      case (st)
        PH_RUN: begin
          if (park_now) begin
            st    <= PH_PARK;
            clk_q <= 1'b0;
          end else if (match) begin
            clk_q <= ~clk_q;
          end
        end
        PH_PARK: begin
          if (!stop_req) begin
            st <= PH_RUN;
          end
        end
        default: st <= PH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/cpu_clk_gen.sv
// Programmable CPU clock generator top level.
module cpu_clk_gen #(
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMP_W-1:0] div_in,
  input  logic             div_load,
  input  logic             stop_req,
  output logic             cpu_clk,
  output logic             wait_en
);
  localparam logic [CMP_W-1:0] FASTEST = '0;

  logic [CMP_W-1:0] act_cmp;
  logic [CMP_W-1:0] cnt;
  logic             match;
  logic             wrap;
  logic             running;

  cpuclk_divreg #(.CMP_W(CMP_W)) u_divreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_in   (div_in),
    .div_load (div_load),
    .apply    (wrap),
    .act_cmp  (act_cmp)
  );

  cpuclk_counter #(.CMP_W(CMP_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .wrap    (wrap),
    .act_cmp (act_cmp),
    .cnt     (cnt),
    .match   (match)
  );

  cpuclk_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_req (stop_req),
    .match    (match),
    .cpu_clk  (cpu_clk),
    .running  (running),
    .wrap     (wrap)
  );

  assign wait_en = (act_cmp == FASTEST);
endmodule

// File: rtl/cpuclk_chk.sv
// Property checker attached to cpu_clk_gen.
module cpuclk_chk #(
  parameter int CMP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic             cpu_clk,
  input logic             wait_en,
  input logic [CMP_W-1:0] cnt,
  input logic [CMP_W-1:0] act_cmp,
  input logic             wrap,
  input logic             running
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_LOW: assert (!cpu_clk); // R1
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act_cmp); // R2

  AST_EDGE_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk != $past(cpu_clk)) |-> $past(cnt == act_cmp)); // R2

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wrap) |-> $stable(act_cmp)); // R4

  AST_PARK_STAY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !cpu_clk) |=> !cpu_clk); // R6

  AST_PARKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !cpu_clk); // R6

  AST_FAST_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_en && running && !stop_req) |=> (cpu_clk != $past(cpu_clk))); // R8
endmodule

bind cpu_clk_gen cpuclk_chk #(.CMP_W(CMP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stop_req (stop_req),
  .cpu_clk  (cpu_clk),
  .wait_en  (wait_en),
  .cnt      (cnt),
  .act_cmp  (act_cmp),
  .wrap     (wrap),
  .running  (running)
);

// File: tb/sim_cpu_clk_gen.sv
module sim_cpu_clk_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_in = 8'd0;
  logic       div_load = 1'b0;
  logic       stop_req = 1'b0;
  logic       cpu_clk;
  logic       wait_en;

  typedef struct {
    int    len;
    bit    at_least;
    string tag;
  } half_t;

  half_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  logic  seen = 1'b0;
  int    cur = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_clk_gen u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_in   (div_in),
    .div_load (div_load),
    .stop_req (stop_req),
    .cpu_clk  (cpu_clk),
    .wait_en  (wait_en)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: measures each half-period and compares against the queue
  initial begin
    logic prev;
    bit   started;
    int   n;
    half_t e;
    prev = 1'b0; started = 1'b0; n = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        started = 1'b0; n = 0; prev = cpu_clk;
      end else begin
        n++;
        if (cpu_clk != prev) begin
          if (started) begin
            if (q.size() == 0) begin
              check(1'b0, "R6 unexpected edge", n, 0);
            end else begin
              e = q.pop_front();
              check(e.at_least ? (n >= e.len) : (n == e.len), e.tag, n, e.len);
            end
          end
          started = 1'b1; n = 0; prev = cpu_clk;
        end
      end
    end
  end

  task automatic push(int len, bit at_least, string tag);
    half_t e;
    e.len = len; e.at_least = at_least; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_edge();
    do @(negedge clk); while (cpu_clk == seen);
    seen = cpu_clk;
  endtask

  task automatic halves(int n, string tag);
    for (int i = 0; i < n; i++) begin
      push(cur + 1, 1'b0, tag);
      wait_edge();
    end
  endtask

  // R4: load just after an output edge
  task automatic change_div(int v, string tag);
    div_in = 8'(v); div_load = 1'b1;
    push(cur + 1, 1'b0, tag);
    @(negedge clk);
    div_load = 1'b0;
    while (cpu_clk == seen) @(negedge clk);
    seen = cpu_clk;
    if (cur == 0) begin
      push(1, 1'b0, "R4 extra old half");
      wait_edge();
    end
    cur = v;
  endtask

  // R5: two loads before one wrap (needs cur >= 2)
  task automatic change_twice(int v1, int v2);
    div_in = 8'(v1); div_load = 1'b1;
    push(cur + 1, 1'b0, "R5 old half");
    @(negedge clk);
    div_in = 8'(v2);
    @(negedge clk);
    div_load = 1'b0;
    while (cpu_clk == seen) @(negedge clk);
    seen = cpu_clk;
    cur = v2;
  endtask

  // R6/R7: stop at a chosen output level, park, release
  task automatic park_at(logic lvl, int idle);
    while (seen != lvl) halves(1, "R2 pre-stop");
    stop_req = 1'b1;
    if (lvl) begin
      push(cur + 1, 1'b0, "R6 high half completes");
      wait_edge();
    end
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      check(cpu_clk == 1'b0, "R6 parked low", cpu_clk, 0);
    end
    stop_req = 1'b0;
    push(cur + 1, 1'b1, "R7 restart low phase");
    wait_edge();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cpu_clk == 1'b0, "R1 cpu_clk in reset", cpu_clk, 0);
    check(wait_en == 1'b1, "R1 wait_en in reset", wait_en, 1);
    rst_n = 1'b1;
    check(cpu_clk == 1'b0, "R1 cpu_clk after release", cpu_clk, 0);
    wait_edge();
    halves(8, "R3 divide-by-two");
    check(wait_en == 1'b1, "R8 wait_en fast", wait_en, 1);
    change_div(3, "R4 old half at 0");
    check(wait_en == 1'b0, "R8 wait_en at 3", wait_en, 0);
    halves(6, "R2 compare 3");
    change_div(1, "R4 old half at 3");
    halves(4, "R2 compare 1");
    change_div(0, "R4 old half at 1");
    check(wait_en == 1'b1, "R8 wait_en back to 0", wait_en, 1);
    halves(4, "R3 compare 0 again");
    change_div(255, "R4 old half at 0");
    halves(3, "R3 compare 255");
    change_div(4, "R4 old half at 255");
    halves(3, "R2 compare 4");
    change_twice(9, 6);
    halves(4, "R5 last load wins");
    park_at(1'b1, 40);
    halves(4, "R7 after high park");
    park_at(1'b0, 25);
    halves(3, "R7 after low park");
    change_div(0, "R4 old half at 6");
    park_at(1'b1, 20);
    halves(6, "R7 fast after park");
    check(q.size() == 0, "R2 queue drained", q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R2 actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule